// File: doc/BRIEF.md
# Saturating Vector Sum-Across Unit

This unit executes one SIMD instruction. It takes two 128-bit operands, each holding four signed 32-bit lanes. It adds the four lanes of the first operand to the lowest-order lane of the second operand, and it clamps the five-way total to the signed 32-bit range. The clamped value goes into the low-order 32 bits of a 128-bit result. The three upper lanes of the result are zero.

The unit recognises its own instruction word. A vector-enable input gates execution: when the input is low, the unit raises a fault and writes nothing. A sticky saturation flag records every clamp until a clear input drops it. One registered stage follows the issue cycle. Its outputs are the result, a register write enable, the destination index, the fault and a valid strobe. The register file and the fault handler sit outside this unit.

Top module: `vsum_sat_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs are cleared at that edge: `out_valid`, `out_wr_en`, `out_fault`, `out_result`, `out_dst` and `sat_flag` are all 0.
- R2: An issue is accepted only when `in_valid` is 1, `instr[31:26]` equals 4 and `instr[10:0]` equals 0x788. All other instruction bits are ignored for acceptance. If an issue is not accepted, the next cycle shows `out_valid`, `out_wr_en` and `out_fault` at 0 and `out_result` at 0.
- R3: One cycle after an accepted, enabled issue, `out_result[31:0]` equals the low 32 bits of the exact signed sum. That sum is the signed value of `opnd_b[31:0]` plus the four signed lanes of `opnd_a`, taken at bits [31:0], [63:32], [95:64] and [127:96]. This holds whenever the sum lies in [-2^31, 2^31-1].
- R4: If the exact sum is greater than 2^31-1, `out_result[31:0]` is 0x7FFFFFFF.
- R5: If the exact sum is less than -2^31, `out_result[31:0]` is 0x80000000.
- R6: Whenever `out_valid` is 1, `out_result[127:32]` is zero.
- R7: An accepted issue with `vec_en`=1 gives `out_valid`=1 and `out_wr_en`=1 in the next cycle, with `out_dst` equal to `instr[25:21]` of that issue.
- R8: `sat_flag` is sticky. An accepted, enabled issue that clamps sets it to 1 in the next cycle. When no clamp occurs and `sat_clr` is 0, the flag keeps its value.
- R9: `sat_clr`=1 clears `sat_flag` in the next cycle. If a clamping issue arrives in the same cycle as the clear, the flag ends at 1.
- R10: An accepted issue with `vec_en`=0 gives `out_valid`=1, `out_fault`=1, `out_wr_en`=0 and `out_result`=0 in the next cycle. It leaves `sat_flag` unchanged unless `sat_clr` is also 1.
- R11: `opnd_b[127:32]` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe |
| instr | input | 32 | Instruction word |
| opnd_a | input | 128 | Four signed lanes to be summed |
| opnd_b | input | 128 | Accumulator operand; only bits [31:0] are used |
| vec_en | input | 1 | Vector unit enable |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Registered result strobe |
| out_wr_en | output | 1 | Destination register write enable |
| out_dst | output | 5 | Destination register index |
| out_result | output | 128 | Result vector; clamped sum in bits [31:0] |
| out_fault | output | 1 | Vector-unavailable fault |
| sat_flag | output | 1 | Sticky saturation status |

## Verification
The hardest cases to reach from the ports are the exact clamp edges, where a single unit decides between passing the sum through and clamping it. The interplay between the sticky flag, a clear in the same cycle and a disabled issue is also hard to reach. The bench sweeps every combination of eight corner lane values across all five contributing lanes. These values are zero, ±1, both extremes and their neighbours, and a half-scale value. The sweep therefore lands on sums of exactly 2^31-1, 2^31, -2^31 and -2^31-1, on all-maximum and all-minimum operands, and on many near-cancelling mixes. Within the sweep, clears and disabled issues are spread on co-prime cadences. As a result, clears coincide with clamps, and disabled issues follow a set flag.

// File: rtl/vsum_pkg.sv
package vsum_pkg;

    localparam int INSN_W    = 32;
    localparam int RIDX_W    = 5;
    localparam int PRIM_W    = 6;
    localparam int EXT_W     = 11;

    localparam logic [PRIM_W-1:0] PRIM_OP = 6'd4;
    localparam logic [EXT_W-1:0]  EXT_OP  = 11'h788;

    typedef struct packed {
        logic              hit;
        logic [RIDX_W-1:0] dst;
    } dec_t;

    typedef enum logic [1:0] {
        ISS_NONE = 2'd0,
        ISS_RUN  = 2'd1,
        ISS_TRAP = 2'd2
    } issue_e;

    function automatic issue_e classify(input logic valid, input logic hit,
                                        input logic enable);
        if (!(valid && hit))
            return ISS_NONE;
        return enable ? ISS_RUN : ISS_TRAP;
    endfunction

endpackage

// File: rtl/vsum_decode.sv
module vsum_decode
    import vsum_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output dec_t              dec
);
    logic [PRIM_W-1:0] prim;
    logic [EXT_W-1:0]  ext;
    logic              unused_fields;

    assign prim          = instr[INSN_W-1 -: PRIM_W];
    assign ext           = instr[EXT_W-1:0];
    assign unused_fields = ^instr[EXT_W+2*RIDX_W-1:EXT_W];

    always_comb begin
        dec.hit = (prim == PRIM_OP) && (ext == EXT_OP);
        dec.dst = instr[INSN_W-PRIM_W-1 -: RIDX_W];
    end
endmodule

// File: rtl/vsum_reduce.sv
module vsum_reduce #(
    parameter int LANES  = 4,
    parameter int LANE_W = 32,
    parameter int SUM_W  = LANE_W + $clog2(LANES + 1)
) (
    input  logic [LANES*LANE_W-1:0] vec,
    input  logic [LANE_W-1:0]       acc,
    output logic signed [SUM_W-1:0] total
);
    logic signed [SUM_W-1:0] ext [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ext[g] = SUM_W'($signed(vec[g*LANE_W +: LANE_W]));
    end

    always_comb begin
        total = SUM_W'($signed(acc));
        for (int i = 0; i < LANES; i++)
            total = total + ext[i];
    end
endmodule

// File: rtl/vsum_clamp.sv
module vsum_clamp #(
    parameter int LANE_W = 32,
    parameter int SUM_W  = 35
) (
    input  logic signed [SUM_W-1:0] total,
    output logic [LANE_W-1:0]       word,
    output logic                    sat
);
    localparam int PAD = SUM_W - LANE_W + 1;
    localparam logic signed [SUM_W-1:0] HI = {{PAD{1'b0}}, {(LANE_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] LO = {{PAD{1'b1}}, {(LANE_W-1){1'b0}}};

    always_comb begin
        if (total > HI) begin
            word = {1'b0, {(LANE_W-1){1'b1}}};
            sat  = 1'b1;
        end else if (total < LO) begin
            word = {1'b1, {(LANE_W-1){1'b0}}};
            sat  = 1'b1;
        end else begin
            word = total[LANE_W-1:0];
            sat  = 1'b0;
        end
    end
endmodule

// File: rtl/vsum_sat_unit.sv
module vsum_sat_unit
    import vsum_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [INSN_W-1:0]       instr,
    input  logic [LANES*LANE_W-1:0] opnd_a,
    input  logic [LANES*LANE_W-1:0] opnd_b,
    input  logic                    vec_en,
    input  logic                    sat_clr,
    output logic                    out_valid,
    output logic                    out_wr_en,
    output logic [RIDX_W-1:0]       out_dst,
    output logic [LANES*LANE_W-1:0] out_result,
    output logic                    out_fault,
    output logic                    sat_flag
);
    localparam int VEC_W = LANES * LANE_W;
    localparam int SUM_W = LANE_W + $clog2(LANES + 1);

    dec_t                    dec;
    issue_e                  kind;
    logic signed [SUM_W-1:0] total;
    logic [LANE_W-1:0]       clamped;
    logic                    clamp_hit;
    logic                    unused_acc_hi;

    assign unused_acc_hi = ^opnd_b[VEC_W-1:LANE_W];

    vsum_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    vsum_reduce #(.LANES(LANES), .LANE_W(LANE_W), .SUM_W(SUM_W)) u_red (
        .vec   (opnd_a),
        .acc   (opnd_b[LANE_W-1:0]),
        .total (total)
    );

    vsum_clamp #(.LANE_W(LANE_W), .SUM_W(SUM_W)) u_clamp (
        .total (total),
        .word  (clamped),
        .sat   (clamp_hit)
    );

    assign kind = classify(in_valid, dec.hit, vec_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_wr_en  <= 1'b0;
            out_fault  <= 1'b0;
            out_dst    <= '0;
            out_result <= '0;
            sat_flag   <= 1'b0;
        end else begin
            out_valid  <= (kind != ISS_NONE);
            out_wr_en  <= (kind == ISS_RUN);
            out_fault  <= (kind == ISS_TRAP);
            out_dst    <= (kind != ISS_NONE) ? dec.dst : '0;
            out_result <= (kind == ISS_RUN) ? {{(VEC_W-LANE_W){1'b0}}, clamped} : '0;
            sat_flag   <= (sat_flag && !sat_clr) || (kind == ISS_RUN && clamp_hit);
        end
    end
endmodule

// File: rtl/vsum_sat_unit_chk.sv
module vsum_sat_unit_chk
    import vsum_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [INSN_W-1:0]       instr,
    input logic                    vec_en,
    input logic                    sat_clr,
    input logic                    out_valid,
    input logic                    out_wr_en,
    input logic [RIDX_W-1:0]       out_dst,
    input logic [LANES*LANE_W-1:0] out_result,
    input logic                    out_fault,
    input logic                    sat_flag
);
    localparam int VEC_W = LANES * LANE_W;

    logic hit;
    logic unused_fields;
    assign hit = (instr[31:26] == PRIM_OP) && (instr[10:0] == EXT_OP);
    assign unused_fields = ^instr[20:11];

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_wr_en && !out_fault && !sat_flag && out_result == '0));

    assert_miss_R2: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && hit) |=> (!out_valid && !out_wr_en && !out_fault));

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_result[VEC_W-1:LANE_W] == '0);

    assert_write_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hit && vec_en) |=>
            (out_valid && out_wr_en && !out_fault && out_dst == $past(instr[25:21])));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !sat_clr) |=> sat_flag);

    // R4 and R5: a rising flag always comes with a clamped word being written
    assert_rise_clamped_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_flag) |-> (out_wr_en &&
            (out_result[LANE_W-1:0] == {1'b0, {(LANE_W-1){1'b1}}} ||
             out_result[LANE_W-1:0] == {1'b1, {(LANE_W-1){1'b0}}})));

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (sat_clr && !(in_valid && hit && vec_en)) |=> !sat_flag);

    assert_fault_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hit && !vec_en) |=>
            (out_valid && out_fault && !out_wr_en && out_result == '0));

    assert_fault_sat_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hit && !vec_en && !sat_clr) |=> $stable(sat_flag));
endmodule

bind vsum_sat_unit vsum_sat_unit_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .instr      (instr),
    .vec_en     (vec_en),
    .sat_clr    (sat_clr),
    .out_valid  (out_valid),
    .out_wr_en  (out_wr_en),
    .out_dst    (out_dst),
    .out_result (out_result),
    .out_fault  (out_fault),
    .sat_flag   (sat_flag)
);

// File: tb/sim_vsum_sat_unit.sv
`timescale 1ns/1ps
module sim_vsum_sat_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] opnd_a = '0;
    logic [127:0] opnd_b = '0;
    logic         vec_en = 1'b0;
    logic         sat_clr = 1'b0;
    logic         out_valid, out_wr_en, out_fault, sat_flag;
    logic [4:0]   out_dst;
    logic [127:0] out_result;

    int  total = 0;
    int  bad = 0;
    bit  exp_sat = 1'b0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    vsum_sat_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .vec_en(vec_en), .sat_clr(sat_clr),
        .out_valid(out_valid), .out_wr_en(out_wr_en), .out_dst(out_dst),
        .out_result(out_result), .out_fault(out_fault), .sat_flag(sat_flag)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] corner(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            5: return 32'h7FFF_FFFE;
            6: return 32'h8000_0001;
            default: return 32'h4000_0000;
        endcase
    endfunction

    function automatic logic [31:0] mk_instr(input logic [5:0] prim, input logic [4:0] d,
                                             input logic [9:0] srcs, input logic [10:0] ext);
        return {prim, d, srcs, ext};
    endfunction

    // drive one issue at a falling edge, check the registered outputs one cycle later
    task automatic run_op(input logic [31:0] ins, input logic [127:0] a, input logic [127:0] b,
                          input bit v, input bit en, input bit clr);
        bit     acc, run, clamp;
        longint s;
        logic [31:0] w;
        in_valid = v; instr = ins; opnd_a = a; opnd_b = b; vec_en = en; sat_clr = clr;
        @(posedge clk);
        @(negedge clk);
        acc = v && (ins[31:26] == 6'd4) && (ins[10:0] == 11'h788);
        run = acc && en;
        s = longint'($signed(b[31:0]));
        for (int i = 0; i < 4; i++) s += longint'($signed(a[i*32 +: 32]));
        clamp = 1'b0;
        if (s > 64'sd2147483647) begin w = 32'h7FFF_FFFF; clamp = 1'b1; end
        else if (s < -64'sd2147483648) begin w = 32'h8000_0000; clamp = 1'b1; end
        else w = s[31:0];
        if (clr) exp_sat = 1'b0;
        if (run && clamp) exp_sat = 1'b1;

        check("R2 valid", {127'd0, out_valid}, {127'd0, acc});
        check("R7 R10 wr_en", {127'd0, out_wr_en}, {127'd0, run});
        check("R10 fault", {127'd0, out_fault}, {127'd0, acc && !en});
        if (run) begin
            if (s > 64'sd2147483647)
                check("R4 R11 result", out_result, {96'd0, w});
            else if (s < -64'sd2147483648)
                check("R5 R11 result", out_result, {96'd0, w});
            else
                check("R3 R11 result", out_result, {96'd0, w});
            check("R7 dst", {123'd0, out_dst}, {123'd0, ins[25:21]});
        end else begin
            check("R2 R10 result", out_result, 128'd0);
        end
        check("R6 upper", {32'd0, out_result[127:32]}, 128'd0);
        check("R8 R9 sat", {127'd0, sat_flag}, {127'd0, exp_sat});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] good;
        int cnt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid", {127'd0, out_valid}, 128'd0);
        check("R1 result", out_result, 128'd0);
        check("R1 sat", {127'd0, sat_flag}, 128'd0);
        rst = 1'b0;

        good = mk_instr(6'd4, 5'd9, 10'h155, 11'h788);
        // R4 all-max operands, then R5 all-min operands
        run_op(good, {4{32'h7FFF_FFFF}}, {96'd0, 32'h7FFF_FFFF}, 1, 1, 0);
        run_op(good, {4{32'h8000_0000}}, {96'd0, 32'h8000_0000}, 1, 1, 0);
        // R10 disabled issue keeps the flag set
        run_op(good, {4{32'h7FFF_FFFF}}, 128'd5, 1, 0, 0);
        // R9 clear with no issue
        run_op(good, 128'd0, 128'd0, 0, 1, 1);
        // R2 decode misses: wrong primary, wrong extended, no strobe
        run_op(mk_instr(6'd5, 5'd1, 10'd0, 11'h788), {4{32'h7FFF_FFFF}}, 128'd1, 1, 1, 0);
        run_op(mk_instr(6'd4, 5'd1, 10'd0, 11'h789), {4{32'h7FFF_FFFF}}, 128'd1, 1, 1, 0);
        run_op(good, {4{32'h7FFF_FFFF}}, 128'd1, 0, 1, 0);
        // R10 disabled issue with clear in the same cycle
        run_op(good, 128'd0, 128'd0, 1, 0, 1);

        // R3 R4 R5 R8 R9 R11: sweep of corner values over all five lanes
        cnt = 0;
        for (int i0 = 0; i0 < 8; i0++)
          for (int i1 = 0; i1 < 8; i1++)
            for (int i2 = 0; i2 < 8; i2++)
              for (int i3 = 0; i3 < 8; i3++)
                for (int ib = 0; ib < 8; ib++) begin
                    cnt++;
                    run_op(mk_instr(6'd4, cnt[4:0], cnt[14:5], 11'h788),
                           {corner(i0), corner(i1), corner(i2), corner(i3)},
                           {{3{cnt ^ 32'hA5A5_0F0F}}, corner(ib)},
                           1, (cnt % 13) != 6, (cnt % 17) == 3);
                end

        in_valid = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule